// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple request port and a four-bank synchronous DRAM. It powers the memory up, programs its mode register, and turns each accepted host request into the ACTIVE, READ, WRITE and PRECHARGE commands it needs. It drives a command/address bus that the memory samples on the rising clock edge. It keeps at most one row open in the whole device. When the periodic refresh timer expires, it closes that row and issues AUTO REFRESH, which takes priority over new host requests.

CAS latency and read burst length are chosen at run time. The values on the configuration inputs are written into the mode register during power-up, and again whenever a reload is requested. Read data is captured after whichever latency was last loaded. Each READ returns a burst of beats. Every WRITE is a single beat with a per-byte mask.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset only NOP (code 4'b0111) is driven for at least INIT_CYC cycles. The controller then issues, in order, PRECHARGE with address bit 10 high, INIT_REFS AUTO REFRESH commands and LOAD MODE. `req_ready` stays low until that LOAD MODE has been issued.
- R2: The LOAD MODE address word carries the burst code in bits 2:0 (0=1, 1=2, 2=4, 3=8 beats, taken from `cfg_bl`). Bit 3 is 0, for sequential wrap. Bits 6:4 hold the CAS latency (2 when `cfg_cas3`=0, 3 when it is 1). Bit 9 is 1, for single-beat writes. All other bits are 0.
- R3: A READ or WRITE is sampled no fewer than TRCD cycles after the ACTIVE that opened its row, and only to the bank and row that are open.
- R4: An ACTIVE or AUTO REFRESH is sampled no fewer than TRP cycles after the preceding PRECHARGE.
- R5: No command other than NOP is sampled within TRFC cycles after an AUTO REFRESH.
- R6: After initialisation, the gap between successive AUTO REFRESH commands never exceeds REF_INT plus a bounded service delay of TRFC+TRP+TMRD+24 cycles. No row is open when an AUTO REFRESH is issued.
- R7: Beat i of a read burst is `sd_dq_in` as sampled CL+i clock edges after the memory samples the READ, with CL the loaded latency. The controller delivers exactly BL beats on `rd_valid`/`rd_data`, with column order wrapping sequentially inside the BL-aligned block.
- R8: A WRITE drives `sd_dq_oe` high in its command cycle with the request data. It drives `sd_dqm` from `req_mask`, where bit b high blocks byte b, so the masked byte keeps its old content. `sd_dq_oe` is low in every other cycle.
- R9: A request to the open bank and row issues no ACTIVE. A request to any other row first precharges only the open bank (address bit 10 low), then activates the new row.
- R10: A pulse on `cfg_load` makes the controller close any open row and reissue LOAD MODE with the current configuration inputs. Later reads use the new latency and burst length.
- R11: Command codes on `sd_cmd` are {cs_n,ras_n,cas_n,we_n}, with LOAD MODE 0000, AUTO REFRESH 0001, PRECHARGE 0010, ACTIVE 0011, WRITE 0100, READ 0101 and NOP 0111. No other code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| cfg_bl | input | 2 | Read burst code: beats = 1 << cfg_bl |
| cfg_load | input | 1 | One-cycle pulse requesting a mode register reload |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DQ_W | Write data |
| req_mask | input | DQ_W/8 | Byte mask, 1 blocks the byte |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DQ_W | Read beat data |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row, column or mode word |
| sd_dq_out | output | DQ_W | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dqm | output | DQ_W/8 | Data mask to memory |
| sd_dq_in | input | DQ_W | Read data from memory |

## Verification
The bound checker watches the command stream on every cycle. It checks that no ACTIVE-to-access, precharge-to-activate or refresh-to-command gap is shorter than its parameter, that no refresh reaches an open row, that the gap between refreshes stays bounded, that the write enable goes with WRITE alone, and that the host port stays closed before the first mode load. Only the bench scenarios can show the data side: the order of the initialisation sequence and the exact mode word, that read beats arrive after the loaded latency at both settings and in wrapped column order, that masked bytes survive, and that row hits skip the ACTIVE while row misses precharge a single bank.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP, ST_PREALL, ST_REF, ST_MRS, ST_IDLE,
        ST_PRE, ST_ACT, ST_RW, ST_WAIT
    } ctl_state_e;

    typedef struct packed {
        logic       cas3;   // 1: latency 3, 0: latency 2
        logic [1:0] bl;     // beats = 1 << bl
    } mode_t;

    function automatic logic [12:0] mode_word(mode_t m);
        logic [12:0] w;
        w      = '0;
        w[2:0] = {1'b0, m.bl};
        w[6:4] = m.cas3 ? 3'd3 : 3'd2;
        w[9]   = 1'b1;          // single-beat writes
        return w;
    endfunction

    function automatic logic [3:0] beats(logic [1:0] bl);
        return 4'd1 << bl;
    endfunction

endpackage

// File: rtl/sdc_refresh_tick.sv
`timescale 1ns/1ps
module sdc_refresh_tick #(
    parameter int INTERVAL = 2083
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= CW'(INTERVAL - 1);
            due <= 1'b0;
        end else begin
            if (cnt == '0) begin
                cnt <= CW'(INTERVAL - 1);
                due <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdc_read_capture.sv
`timescale 1ns/1ps
module sdc_read_capture
    import sdc_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_issued,   // READ on the bus this cycle
    input  mode_t           mode,
    input  logic [DQ_W-1:0] dq_in,
    output logic            rd_valid,
    output logic [DQ_W-1:0] rd_data
);
    localparam int MAX_CL = 3;

    logic [MAX_CL-1:0] age;
    logic [3:0]        left;
    logic              first_beat;

    always_comb first_beat = mode.cas3 ? age[2] : age[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            age      <= '0;
            left     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            age <= {age[MAX_CL-2:0], rd_issued};
            if (first_beat) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
                left     <= beats(mode.bl) - 4'd1;
            end else if (left != '0) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
                left     <= left - 4'd1;
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl.sv
`timescale 1ns/1ps
module sdram_seq_ctrl
    import sdc_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int DQ_W      = 16,
    parameter int INIT_CYC  = 26600,
    parameter int REF_INT   = 2083,
    parameter int TRCD      = 3,
    parameter int TRP       = 3,
    parameter int TRFC      = 9,
    parameter int TMRD      = 2,
    parameter int TWR       = 2,
    parameter int INIT_REFS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_cas3,
    input  logic [1:0]                    cfg_bl,
    input  logic                          cfg_load,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]               req_wdata,
    input  logic [DQ_W/8-1:0]             req_mask,
    output logic                          rd_valid,
    output logic [DQ_W-1:0]               rd_data,
    output logic [3:0]                    sd_cmd,
    output logic [BANK_W-1:0]             sd_ba,
    output logic [ROW_W-1:0]              sd_addr,
    output logic [DQ_W-1:0]               sd_dq_out,
    output logic                          sd_dq_oe,
    output logic [DQ_W/8-1:0]             sd_dqm,
    input  logic [DQ_W-1:0]               sd_dq_in
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int MASK_W = DQ_W / 8;
    localparam int TMAX   = (INIT_CYC > 64) ? INIT_CYC : 64;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int RW_W   = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] A10 = ROW_W'(1) << 10;

    ctl_state_e          st, ret;
    logic [TW-1:0]       tmr;
    logic [RW_W-1:0]     refs_left;
    logic                init_done, mrs_pend, pre_all;
    logic                open_v;
    logic [BANK_W-1:0]   open_bank, cur_bank;
    logic [ROW_W-1:0]    open_row, cur_row;
    logic [COL_W-1:0]    cur_col;
    logic                cur_wr;
    logic [DQ_W-1:0]     cur_data;
    logic [MASK_W-1:0]   cur_mask;
    mode_t               mode, cfg_m;
    logic                ref_due, ref_ack, hit;
    logic [BANK_W-1:0]   a_bank;
    logic [ROW_W-1:0]    a_row;

    assign cfg_m   = '{cas3: cfg_cas3, bl: cfg_bl};
    assign a_bank  = req_addr[ADDR_W-1 -: BANK_W];
    assign a_row   = req_addr[COL_W +: ROW_W];
    assign hit     = open_v && (a_bank == open_bank) && (a_row == open_row);
    assign ref_ack = (st == ST_REF) && init_done;
    assign req_ready = (st == ST_IDLE) && !ref_due && !mrs_pend;

    sdc_refresh_tick #(.INTERVAL(REF_INT)) u_tick (
        .clk(clk), .rst(rst), .en(init_done), .ack(ref_ack), .due(ref_due)
    );

    sdc_read_capture #(.DQ_W(DQ_W)) u_cap (
        .clk(clk), .rst(rst), .rd_issued(sd_cmd == CMD_RD), .mode(mode),
        .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PWRUP;
            ret       <= ST_IDLE;
            tmr       <= TW'(INIT_CYC - 1);
            refs_left <= RW_W'(INIT_REFS);
            init_done <= 1'b0;
            mrs_pend  <= 1'b0;
            pre_all   <= 1'b0;
            open_v    <= 1'b0;
            open_bank <= '0;
            open_row  <= '0;
            cur_bank  <= '0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_wr    <= 1'b0;
            cur_data  <= '0;
            cur_mask  <= '0;
            mode      <= '0;
            sd_cmd    <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            sd_dqm    <= '0;
        end else begin
            sd_cmd   <= CMD_NOP;
            sd_dq_oe <= 1'b0;
            sd_dqm   <= '0;
            case (st)
                ST_PWRUP: begin
                    if (tmr == '0) st <= ST_PREALL;
                    else           tmr <= tmr - 1'b1;
                end
                ST_PREALL: begin
                    sd_cmd  <= CMD_PRE;
                    sd_addr <= A10;
                    open_v  <= 1'b0;
                    tmr     <= TW'(TRP - 1);
                    ret     <= ST_REF;
                    st      <= ST_WAIT;
                end
                ST_REF: begin
                    sd_cmd <= CMD_REF;
                    tmr    <= TW'(TRFC - 1);
                    st     <= ST_WAIT;
                    if (!init_done) begin
                        refs_left <= refs_left - 1'b1;
                        ret <= (refs_left == RW_W'(1)) ? ST_MRS : ST_REF;
                    end else begin
                        ret <= ST_IDLE;
                    end
                end
                ST_MRS: begin
                    sd_cmd    <= CMD_MRS;
                    sd_ba     <= '0;
                    sd_addr   <= ROW_W'(mode_word(cfg_m));
                    mode      <= cfg_m;
                    mrs_pend  <= 1'b0;
                    init_done <= 1'b1;
                    tmr       <= TW'(TMRD - 1);
                    ret       <= ST_IDLE;
                    st        <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_due || mrs_pend) begin
                        pre_all <= 1'b1;
                        if (open_v) begin
                            st  <= ST_PRE;
                            ret <= ref_due ? ST_REF : ST_MRS;
                        end else begin
                            st  <= ref_due ? ST_REF : ST_MRS;
                        end
                    end else if (req_valid) begin
                        cur_bank <= a_bank;
                        cur_row  <= a_row;
                        cur_col  <= req_addr[COL_W-1:0];
                        cur_wr   <= req_write;
                        cur_data <= req_wdata;
                        cur_mask <= req_mask;
                        pre_all  <= 1'b0;
                        if (hit) begin
                            st <= ST_RW;
                        end else if (open_v) begin
                            st  <= ST_PRE;
                            ret <= ST_ACT;
                        end else begin
                            st <= ST_ACT;
                        end
                    end
                end
                ST_PRE: begin
                    sd_cmd  <= CMD_PRE;
                    sd_ba   <= open_bank;
                    sd_addr <= pre_all ? A10 : '0;
                    open_v  <= 1'b0;
                    tmr     <= TW'(TRP - 1);
                    st      <= ST_WAIT;
                end
                ST_ACT: begin
                    sd_cmd    <= CMD_ACT;
                    sd_ba     <= cur_bank;
                    sd_addr   <= cur_row;
                    open_v    <= 1'b1;
                    open_bank <= cur_bank;
                    open_row  <= cur_row;
                    tmr       <= TW'(TRCD - 1);
                    ret       <= ST_RW;
                    st        <= ST_WAIT;
                end
                ST_RW: begin
                    sd_ba   <= cur_bank;
                    sd_addr <= ROW_W'(cur_col);
                    ret     <= ST_IDLE;
                    st      <= ST_WAIT;
                    if (cur_wr) begin
                        sd_cmd    <= CMD_WR;
                        sd_dq_oe  <= 1'b1;
                        sd_dq_out <= cur_data;
                        sd_dqm    <= cur_mask;
                        tmr       <= TW'(TWR - 1);
                    end else begin
                        sd_cmd <= CMD_RD;
                        // hold the bus until the last beat has been taken
                        tmr <= TW'(beats(mode.bl)) + (mode.cas3 ? TW'(2) : TW'(1));
                    end
                end
                ST_WAIT: begin
                    if (tmr == '0) st <= ret;
                    else           tmr <= tmr - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
            if (cfg_load) mrs_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sdram_seq_ctrl_chk
    import sdc_pkg::*;
#(
    parameter int TRCD    = 3,
    parameter int TRP     = 3,
    parameter int TRFC    = 9,
    parameter int TMRD    = 2,
    parameter int REF_INT = 2083
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] sd_cmd,
    input logic       sd_dq_oe,
    input logic       req_ready
);
    localparam int SLACK = TRFC + TRP + TMRD + 24;
    localparam int LIM   = REF_INT + SLACK;
    localparam int CW    = $clog2(LIM + 4) + 1;
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    logic [CW-1:0] since_act, since_pre, since_ref;
    logic          mrs_seen, ref_seen, row_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= SAT;
            since_pre <= SAT;
            since_ref <= SAT;
            mrs_seen  <= 1'b0;
            ref_seen  <= 1'b0;
            row_open  <= 1'b0;
        end else begin
            since_act <= (sd_cmd == CMD_ACT) ? CW'(1) : (since_act == SAT ? SAT : since_act + 1'b1);
            since_pre <= (sd_cmd == CMD_PRE) ? CW'(1) : (since_pre == SAT ? SAT : since_pre + 1'b1);
            since_ref <= (sd_cmd == CMD_REF) ? CW'(1) : (since_ref == SAT ? SAT : since_ref + 1'b1);
            if (sd_cmd == CMD_MRS) mrs_seen <= 1'b1;
            if (sd_cmd == CMD_REF && mrs_seen) ref_seen <= 1'b1;
            if (sd_cmd == CMD_ACT) row_open <= 1'b1;
            else if (sd_cmd == CMD_PRE) row_open <= 1'b0;
        end
    end

    assert_ready_after_init_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mrs_seen);

    assert_act_to_access_R3: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> (since_act >= CW'(TRCD)));

    assert_pre_to_act_R4: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_ACT || sd_cmd == CMD_REF) |-> (since_pre >= CW'(TRP)));

    assert_ref_recovery_R5: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd != CMD_NOP) |-> (since_ref >= CW'(TRFC)));

    assert_ref_row_closed_R6: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_REF) |-> !row_open);

    assert_ref_gap_R6: assert property (@(posedge clk) disable iff (rst)
        ref_seen |-> (since_ref <= CW'(LIM)));

    assert_oe_with_write_R8: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (sd_cmd == CMD_WR));

endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(
    .TRCD(TRCD), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .REF_INT(REF_INT)
) u_chk (
    .clk(clk), .rst(rst), .sd_cmd(sd_cmd), .sd_dq_oe(sd_dq_oe), .req_ready(req_ready)
);

// File: tb/sdram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sdram_seq_ctrl_test;
    localparam int INIT_CYC = 40;
    localparam int REF_INT  = 1200;
    localparam int TRCD = 3, TRP = 3, TRFC = 7, TMRD = 2, TWR = 2;
    localparam int SLACK = TRFC + TRP + TMRD + 24;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cfg_cas3 = 1'b0, cfg_load = 1'b0;
    logic [1:0]  cfg_bl = 2'd2;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rd_valid, sd_dq_oe;
    logic [15:0] rd_data, sd_dq_out, sd_dq_in;
    logic [3:0]  sd_cmd;
    logic [1:0]  sd_ba, sd_dqm;
    logic [12:0] sd_addr;

    always #2 clk = ~clk;

    sdram_seq_ctrl #(.INIT_CYC(INIT_CYC), .REF_INT(REF_INT), .TRCD(TRCD), .TRP(TRP),
                     .TRFC(TRFC), .TMRD(TMRD), .TWR(TWR)) uut (
        .clk(clk), .rst(rst), .cfg_cas3(cfg_cas3), .cfg_bl(cfg_bl), .cfg_load(cfg_load),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cmd(sd_cmd), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm),
        .sd_dq_in(sd_dq_in)
    );

    int total = 0, failed = 0;

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model (acts on the command sampled at the next rising edge)
    logic [15:0] mem [int];
    logic [15:0] shadow [int];
    logic [15:0] slot_d [16];
    bit          slot_v [16];
    logic [15:0] rq [$];
    int  cyc = 0, rel_cyc = 0, first_cmd = -1;
    int  pre_cyc = -100000, act_cyc = -100000, ref_cyc = -100000;
    int  m_cl = 2, m_bl = 4, m_open = 0, m_bank = 0, m_row = 0;
    int  v_rcd = 0, v_rp = 0, v_rfc = 0, v_enc = 0, v_open = 0, v_oe = 0;
    int  n_act = 0, n_pre1 = 0, n_ref = 0, n_mrs = 0, max_gap = 0, last_pre_bank = 0;
    int  rd_cmd_cyc = 0, rv_first = -1, rv_last = -1;
    int  nseq = 0;
    logic [3:0]  seq [5];
    logic        seq_a10 [5];
    logic [12:0] mrs_word = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst && sd_cmd != 4'b0111) begin
            if (first_cmd < 0) first_cmd = cyc;
            if (nseq < 5) begin seq[nseq] = sd_cmd; seq_a10[nseq] = sd_addr[10]; nseq++; end
            if (n_ref > 0 && cyc - ref_cyc < TRFC) v_rfc++;
        end
        if (!rst) begin
            case (sd_cmd)
                4'b0111: ;
                4'b0000: begin
                    mrs_word = sd_addr; m_cl = int'(sd_addr[6:4]);
                    m_bl = 1 << sd_addr[2:0]; n_mrs++;
                end
                4'b0011: begin
                    if (cyc - pre_cyc < TRP) v_rp++;
                    m_open = 1; m_bank = sd_ba; m_row = sd_addr; act_cyc = cyc; n_act++;
                end
                4'b0010: begin
                    pre_cyc = cyc; m_open = 0;
                    if (!sd_addr[10]) begin n_pre1++; last_pre_bank = sd_ba; end
                end
                4'b0001: begin
                    if (cyc - pre_cyc < TRP) v_rp++;
                    if (m_open != 0) v_open++;
                    if (n_ref >= 2 && n_mrs > 0 && cyc - ref_cyc > max_gap) max_gap = cyc - ref_cyc;
                    ref_cyc = cyc; n_ref++;
                end
                4'b0100, 4'b0101: begin
                    if (m_open == 0 || m_bank != sd_ba || cyc - act_cyc < TRCD) v_rcd++;
                    if (sd_cmd == 4'b0100) begin
                        automatic int k = int'({sd_ba, m_row[12:0], sd_addr[8:0]});
                        automatic logic [15:0] w = mem.exists(k) ? mem[k] : 16'h0;
                        if (!sd_dq_oe) v_oe++;
                        if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
                        if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
                        mem[k] = w;
                    end else begin
                        rd_cmd_cyc = cyc;
                        for (int i = 0; i < m_bl; i++) begin
                            automatic int c  = (sd_addr[8:0] & ~(m_bl - 1)) | ((sd_addr[8:0] + i) & (m_bl - 1));
                            automatic int k  = int'({sd_ba, m_row[12:0], 9'(c)});
                            automatic int sl = (cyc + m_cl + i) % 16;
                            slot_v[sl] = 1'b1;
                            slot_d[sl] = mem.exists(k) ? mem[k] : 16'h0;
                        end
                    end
                end
                default: v_enc++;
            endcase
        end
        if (sd_dq_oe && sd_cmd != 4'b0100) v_oe++;
        if (slot_v[cyc % 16]) begin
            sd_dq_in = slot_d[cyc % 16]; slot_v[cyc % 16] = 1'b0;
        end else begin
            sd_dq_in = 16'h0;
        end
        if (rd_valid) begin
            rq.push_back(rd_data);
            if (rv_first < 0) rv_first = cyc;
            rv_last = cyc;
        end
    end

    // ---------------- host helpers
    task automatic host_req(bit wr, logic [23:0] a, logic [15:0] d, logic [1:0] m);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host_write(logic [23:0] a, logic [15:0] d, logic [1:0] m);
        automatic logic [15:0] w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (!m[0]) w[7:0]  = d[7:0];
        if (!m[1]) w[15:8] = d[15:8];
        shadow[int'(a)] = w;
        host_req(1'b1, a, d, m);
    endtask

    task automatic read_check(logic [23:0] a, int bl, int cl, string req);
        rq.delete(); rv_first = -1;
        host_req(1'b0, a, 16'h0, 2'b00);
        for (int t = 0; t < 60 && rq.size() < bl; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(rq.size() == bl, req, rq.size(), bl);
        check(rv_first - rd_cmd_cyc == cl + 1, req, rv_first - rd_cmd_cyc, cl + 1);
        check(rv_last - rv_first == bl - 1, req, rv_last - rv_first, bl - 1);
        for (int i = 0; i < bl && i < rq.size(); i++) begin
            automatic int c = (int'(a[8:0]) & ~(bl - 1)) | ((int'(a[8:0]) + i) & (bl - 1));
            automatic int k = int'({a[23:9], 9'(c)});
            automatic logic [15:0] e = shadow.exists(k) ? shadow[k] : 16'h0;
            check(rq[i] === e, req, rq[i], e);
        end
    endtask

    task automatic wait_ready();
        for (int t = 0; t < 500 && !req_ready; t++) @(negedge clk);
    endtask

    function automatic logic [23:0] mk(int b, int r, int c);
        return {2'(b), 13'(r), 9'(c)};
    endfunction

    // ---------------- scenarios
    task automatic t_reset_init();
        repeat (3) @(negedge clk);
        rst = 1'b0; rel_cyc = cyc;
        @(negedge clk);
        check(req_ready == 1'b0, "R1 ready low after reset", req_ready, 0);
        check(sd_cmd == 4'b0111, "R1 NOP after reset", sd_cmd, 4'b0111);
        wait_ready();
        check(first_cmd - rel_cyc >= INIT_CYC, "R1 power-up wait", first_cmd - rel_cyc, INIT_CYC);
        check(seq[0] == 4'b0010 && seq_a10[0], "R1 precharge all first", {seq[0], seq_a10[0]}, 5'b00101);
        check(seq[1] == 4'b0001 && seq[2] == 4'b0001, "R1 two refreshes", {seq[1], seq[2]}, 8'h11);
        check(seq[3] == 4'b0000, "R1 mode load last", seq[3], 0);
        check(mrs_word == 13'h222, "R2 mode word CL2 BL4", mrs_word, 13'h222);
        check(req_ready == 1'b1, "R1 ready after init", req_ready, 1);
    endtask

    task automatic t_write_read_cl2();
        for (int i = 0; i < 4; i++) host_write(mk(1, 5, 8 + i), 16'h1100 + 16'(i * 16'h0111), 2'b00);
        read_check(mk(1, 5, 9), 4, 2, "R7 CL2 wrapped burst");
    endtask

    task automatic t_mask_and_hit();
        automatic int a0 = n_act;
        host_write(mk(1, 5, 8), 16'hABCD, 2'b01);
        host_write(mk(1, 5, 10), 16'h5A5A, 2'b10);
        read_check(mk(1, 5, 8), 4, 2, "R8 masked bytes kept");
        check(n_act == a0, "R9 row hit issues no ACTIVE", n_act - a0, 0);
    endtask

    task automatic t_row_miss();
        automatic int a0 = n_act, p0 = n_pre1;
        for (int i = 0; i < 8; i++) host_write(mk(2, 7, 8 + i), 16'hC000 + 16'(i * 16'h0101), 2'b00);
        check(n_pre1 - p0 == 1, "R9 single-bank precharge on miss", n_pre1 - p0, 1);
        check(last_pre_bank == 1, "R9 precharge targets open bank", last_pre_bank, 1);
        check(n_act - a0 == 1, "R9 one ACTIVE for new row", n_act - a0, 1);
    endtask

    task automatic t_reload_cl3();
        automatic int m0 = n_mrs;
        cfg_cas3 = 1'b1; cfg_bl = 2'd3;
        cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
        @(negedge clk);
        wait_ready();
        check(n_mrs - m0 == 1, "R10 mode reloaded", n_mrs - m0, 1);
        check(mrs_word == 13'h233, "R2 R10 mode word CL3 BL8", mrs_word, 13'h233);
        check(m_open == 0, "R10 row closed before reload", m_open, 0);
        read_check(mk(2, 7, 13), 8, 3, "R10 R7 CL3 burst of 8");
    endtask

    task automatic t_refresh();
        automatic int r0 = n_ref;
        repeat (3 * REF_INT) @(negedge clk);
        check(n_ref - r0 >= 2, "R6 periodic refresh", n_ref - r0, 2);
        check(max_gap <= REF_INT + SLACK, "R6 refresh gap bound", max_gap, REF_INT + SLACK);
        read_check(mk(1, 5, 8), 8, 3, "R6 data kept across refresh");
        check(v_open == 0, "R6 refresh with row open", v_open, 0);
    endtask

    task automatic t_spacing();
        check(v_rcd == 0, "R3 ACTIVE to access spacing", v_rcd, 0);
        check(v_rp == 0, "R4 precharge spacing", v_rp, 0);
        check(v_rfc == 0, "R5 refresh recovery", v_rfc, 0);
        check(v_oe == 0, "R8 drive enable with WRITE only", v_oe, 0);
        check(v_enc == 0, "R11 command encoding", v_enc, 0);
    endtask

    bit done = 1'b0;

    initial begin
        sd_dq_in = '0;
        t_reset_init();
        t_write_read_cl2();
        t_mask_and_hit();
        t_row_miss();
        t_reload_cl3();
        t_refresh();
        t_spacing();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule